// File: doc/BRIEF.md
# Timer master trigger output selector

This block forms the trigger output that a master timer hands to its slave timers. A 3-bit master-mode field picks the source of that trigger. In reset mode the output carries a single-cycle pulse. The pulse comes from a software update-generate strobe, or from a reset raised by the slave-mode controller; the slave-controller case arrives one cycle later than the software case. In enable mode the output follows the counter-enable level. That level is the software enable bit, OR-ed with the pause-mode trigger level while pause mode is active. The pause-mode contribution is held back by one register unless the master-slave flag is set, in which case it goes straight through. The remaining mode codes hold the output low.

The block also produces the channel 0 trigger input. A select bit chooses between the channel 0 pin on its own and the XOR of the channel 0, 1 and 2 pins. All pins are plain control signals with no valid/ready handshake, because nothing here is a data stream. Both outputs are registered, and both clear to 0 on the asynchronous active-low reset.

Top module: `trgo_master_sel`

## Requirements
- R1: While `rst_n` is low, `trgo` and `ch0_trig` are 0.
- R2: With `mm_mode` = 3'b000, an `upd_gen` pulse one cycle wide in cycle t makes `trgo` high in cycle t+1 only.
- R3: With `mm_mode` = 3'b000, a `slv_rst` pulse one cycle wide in cycle t makes `trgo` high in cycle t+2 only. `trgo` stays low in cycle t+1.
- R4: With `mm_mode` = 3'b001, `trgo` in cycle t+1 equals `cnt_en` of cycle t whenever the pause term is low.
- R5: With `mm_mode` = 3'b001 and `cnt_en` low, the pause term (`pause_mode` AND `pause_trig`) reaches `trgo` after one cycle when `msm_en` = 1, and after two cycles when `msm_en` = 0.
- R6: With `mm_mode` in 3'b010 to 3'b111, `trgo` is 0 in the following cycle, whatever the other inputs do.
- R7: With `ch0_xor_sel` = 0, `ch0_trig` in cycle t+1 equals `ch_pin[0]` of cycle t.
- R8: With `ch0_xor_sel` = 1, `ch0_trig` in cycle t+1 equals `ch_pin[0]` ^ `ch_pin[1]` ^ `ch_pin[2]` of cycle t.
- R9: With `pause_mode` = 0, `pause_trig` has no effect on `trgo`. In mode 3'b001 with `cnt_en` = 0, `trgo` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mm_mode | input | 3 | Master-mode code: 000 reset pulse, 001 enable level, others low |
| upd_gen | input | 1 | Software update-generate strobe |
| slv_rst | input | 1 | Reset pulse from the slave-mode controller |
| cnt_en | input | 1 | Software counter-enable bit |
| pause_mode | input | 1 | Slave controller is in pause mode |
| pause_trig | input | 1 | Trigger input level used in pause mode |
| msm_en | input | 1 | Master-slave mode flag; bypasses the pause delay |
| ch_pin | input | 3 | Channel 0..2 input pins |
| ch0_xor_sel | input | 1 | 0: channel 0 pin, 1: XOR of channel 0..2 pins |
| trgo | output | 1 | Trigger output to slave timers |
| ch0_trig | output | 1 | Channel 0 trigger input |

## Verification
Counting from the clock edge that samples a stimulus, these results are due one cycle later: the software strobe, the enable bit, the undelayed pause path and the channel 0 trigger. The slave-controller reset pulse and the delayed pause path are due one cycle after that, two cycles in all. A behavioural model in the bench keeps one cycle of input history, predicts both outputs at every rising edge, and compares them half a period later at the falling edge, when the registers have settled. Directed sequences also probe the exact cycle before, at and after each delayed pulse, so that an output one cycle early or one cycle late is caught.

// File: rtl/trgo_pkg.sv
package trgo_pkg;
  localparam int MM_W = 3;

  typedef enum logic [MM_W-1:0] {
    MM_RESET  = 3'b000,
    MM_ENABLE = 3'b001
  } mm_mode_e;
endpackage

// File: rtl/trgo_rst_pulse.sv
// Reset-mode pulse source: software strobe passes at once, slave-controller
// reset is staged through one extra register.
module trgo_rst_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_gen,
  input  logic slv_rst,
  output logic fire
);
  logic slv_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slv_stage <= 1'b0;
    else        slv_stage <= slv_rst;
  end

  assign fire = upd_gen | slv_stage;

  // R3
  slv_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_rst |=> fire);
endmodule

// File: rtl/trgo_en_path.sv
// Enable-mode level: software enable OR pause-mode gate; the gate is delayed
// one cycle unless master-slave mode bypasses the register.
module trgo_en_path (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  input  logic pause_mode,
  input  logic pause_trig,
  input  logic msm_en,
  output logic en_lvl
);
  logic gate_now;
  logic gate_dly;
  logic gate_sel;

  assign gate_now = pause_mode & pause_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_dly <= 1'b0;
    else        gate_dly <= gate_now;
  end

  assign gate_sel = msm_en ? gate_now : gate_dly;
  assign en_lvl   = cnt_en | gate_sel;

  // R9
  no_pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pause_mode && !cnt_en && !gate_dly) |-> !en_lvl);
endmodule

// File: rtl/trgo_ch0_sel.sv
// Channel 0 trigger input: single pin or XOR across NCH pins, registered.
module trgo_ch0_sel #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xor_sel,
  input  logic [NCH-1:0] ch_pin,
  output logic           ch0_trig
);
  logic [NCH-1:0] xr;

  assign xr[0] = ch_pin[0];
  generate
    for (genvar i = 1; i < NCH; i++) begin : g_xor
      assign xr[i] = xr[i-1] ^ ch_pin[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ch0_trig <= 1'b0;
    else if (xor_sel) ch0_trig <= xr[NCH-1];
    else              ch0_trig <= ch_pin[0];
  end

  // R7
  pin_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xor_sel |=> ch0_trig == $past(ch_pin[0]));

  // R8
  xor_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xor_sel |=> ch0_trig == $past(^ch_pin));
endmodule

// File: rtl/trgo_master_sel.sv
module trgo_master_sel
  import trgo_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [MM_W-1:0] mm_mode,
  input  logic            upd_gen,
  input  logic            slv_rst,
  input  logic            cnt_en,
  input  logic            pause_mode,
  input  logic            pause_trig,
  input  logic            msm_en,
  input  logic [NCH-1:0]  ch_pin,
  input  logic            ch0_xor_sel,
  output logic            trgo,
  output logic            ch0_trig
);
  logic fire;
  logic en_lvl;

  trgo_rst_pulse u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_gen (upd_gen),
    .slv_rst (slv_rst),
    .fire    (fire)
  );

  trgo_en_path u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .pause_mode (pause_mode),
    .pause_trig (pause_trig),
    .msm_en     (msm_en),
    .en_lvl     (en_lvl)
  );

  trgo_ch0_sel #(.NCH(NCH)) u_ch0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .xor_sel  (ch0_xor_sel),
    .ch_pin   (ch_pin),
    .ch0_trig (ch0_trig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trgo <= 1'b0;
    else begin
      case (mm_mode_e'(mm_mode))
        MM_RESET:  trgo <= fire;
        MM_ENABLE: trgo <= en_lvl;
        default:   trgo <= 1'b0;
      endcase
    end
  end

  // R2
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_mode == MM_RESET && upd_gen) |=> trgo);

  // R3
  slv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_mode == MM_RESET && slv_rst) ##1 (mm_mode == MM_RESET) |=> trgo);

  // R4
  cen_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_mode == MM_ENABLE && cnt_en) |=> trgo);

  // R5
  msm_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_mode == MM_ENABLE && msm_en && pause_mode && pause_trig) |=> trgo);

  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_mode > MM_ENABLE) |=> !trgo);
endmodule

// File: tb/test_trgo_master_sel.sv
`timescale 1ns/1ps
module test_trgo_master_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mm_mode = 3'b000;
  logic       upd_gen = 1'b0, slv_rst = 1'b0, cnt_en = 1'b0;
  logic       pause_mode = 1'b0, pause_trig = 1'b0, msm_en = 1'b0;
  logic [2:0] ch_pin = 3'b000;
  logic       ch0_xor_sel = 1'b0;
  logic       trgo, ch0_trig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trgo_master_sel i_trgo_master_sel (
    .clk(clk), .rst_n(rst_n), .mm_mode(mm_mode), .upd_gen(upd_gen),
    .slv_rst(slv_rst), .cnt_en(cnt_en), .pause_mode(pause_mode),
    .pause_trig(pause_trig), .msm_en(msm_en), .ch_pin(ch_pin),
    .ch0_xor_sel(ch0_xor_sel), .trgo(trgo), .ch0_trig(ch0_trig)
  );

  // Behavioural reference: one cycle of input history, prediction at each edge.
  bit    exp_trgo = 0, exp_ch0 = 0, h_slv = 0, h_gate = 0, model_on = 0;
  string trgo_req = "R1", ch0_req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_trgo = 0; exp_ch0 = 0; h_slv = 0; h_gate = 0; model_on = 0;
    end else begin
      bit gate;
      gate = pause_mode && pause_trig;
      if (mm_mode == 3'd0) begin
        exp_trgo = upd_gen || h_slv;
        trgo_req = "R2/R3";
      end else if (mm_mode == 3'd1) begin
        exp_trgo = cnt_en || (msm_en ? gate : h_gate);
        trgo_req = "R4/R5/R9";
      end else begin
        exp_trgo = 0;
        trgo_req = "R6";
      end
      if (ch0_xor_sel) begin
        exp_ch0 = ch_pin[0] ^ ch_pin[1] ^ ch_pin[2];
        ch0_req = "R8";
      end else begin
        exp_ch0 = ch_pin[0];
        ch0_req = "R7";
      end
      h_slv = slv_rst;
      h_gate = gate;
      model_on = 1;
    end
  end

  task automatic chk(input bit got, input bit exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && model_on && !done) begin
      chk(trgo, exp_trgo, trgo_req, "trgo model");
      chk(ch0_trig, exp_ch0, ch0_req, "ch0_trig model");
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic quiet();
    upd_gen = 0; slv_rst = 0; cnt_en = 0; pause_mode = 0; pause_trig = 0; msm_en = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    ch_pin = 3'b111;
    ch0_xor_sel = 1;
    upd_gen = 1;
    cnt_en = 1;
    mm_mode = 3'd1;
    repeat (3) tick();
    // R1: outputs held at zero during reset
    chk(trgo, 0, "R1", "trgo in reset");
    chk(ch0_trig, 0, "R1", "ch0_trig in reset");
    quiet();
    mm_mode = 3'd0;
    ch_pin = 0;
    ch0_xor_sel = 0;
    rst_n = 1;
    repeat (2) tick();

    // R2: software strobe -> one-cycle pulse next cycle
    upd_gen = 1; tick(); upd_gen = 0;
    chk(trgo, 1, "R2", "upd pulse t+1");
    tick(); chk(trgo, 0, "R2", "upd pulse t+2");

    // R3: slave reset -> pulse two cycles later only
    tick();
    slv_rst = 1; tick(); slv_rst = 0;
    chk(trgo, 0, "R3", "slv pulse t+1");
    tick(); chk(trgo, 1, "R3", "slv pulse t+2");
    tick(); chk(trgo, 0, "R3", "slv pulse t+3");

    // R4: enable bit followed
    mm_mode = 3'd1;
    cnt_en = 1; tick(); chk(trgo, 1, "R4", "cen high");
    cnt_en = 0; tick(); chk(trgo, 0, "R4", "cen low");

    // R5: pause path delayed without master-slave, bypassed with it
    pause_mode = 1; pause_trig = 1; tick();
    chk(trgo, 0, "R5", "delayed pause t+1");
    tick(); chk(trgo, 1, "R5", "delayed pause t+2");
    pause_trig = 0; tick(); tick(); chk(trgo, 0, "R5", "pause cleared");
    msm_en = 1; pause_trig = 1; tick();
    chk(trgo, 1, "R5", "bypass pause t+1");
    pause_trig = 0; tick(); chk(trgo, 0, "R5", "bypass pause off");

    // R9: trigger ignored outside pause mode
    quiet(); mm_mode = 3'd1; pause_trig = 1;
    repeat (3) begin tick(); chk(trgo, 0, "R9", "trig without pause"); end
    pause_trig = 0;

    // R6: other codes hold low
    for (int m = 2; m < 8; m++) begin
      mm_mode = 3'(m); cnt_en = 1; upd_gen = 1; tick();
      chk(trgo, 0, "R6", "idle code");
    end
    quiet();

    // R7 / R8: channel 0 routing
    for (int p = 0; p < 8; p++) begin
      ch_pin = 3'(p); ch0_xor_sel = 0; tick();
      chk(ch0_trig, ch_pin[0], "R7", "pin route");
      ch0_xor_sel = 1; tick();
      chk(ch0_trig, ch_pin[0] ^ ch_pin[1] ^ ch_pin[2], "R8", "xor route");
    end

    // Mixed stimulus compared every cycle by the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 9);
      mm_mode = (r < 4) ? 3'd0 : (r < 8) ? 3'd1 : 3'($urandom_range(2, 7));
      upd_gen = ($urandom_range(0, 5) == 0);
      slv_rst = ($urandom_range(0, 5) == 0);
      cnt_en = ($urandom_range(0, 3) == 0);
      pause_mode = $urandom_range(0, 1);
      pause_trig = $urandom_range(0, 1);
      msm_en = $urandom_range(0, 1);
      ch_pin = 3'($urandom_range(0, 7));
      ch0_xor_sel = $urandom_range(0, 1);
      tick();
    end
    quiet();
    tick();
    finish_run();
  end
endmodule